// File: doc/BRIEF.md
# Two-wire serial EEPROM slave engine

This block is the target side of a two-wire serial EEPROM. It watches oversampled clock and data lines on the system clock, finds start, repeated start and stop conditions, and checks the control byte that follows each start against a fixed device code and three strap pins. Write transactions load a word pointer from two address bytes and pass the data bytes to a page-write unit. That unit stores them in a page buffer and copies them into the internal array after the stop condition. Read transactions stream bytes from the word pointer for as long as the master keeps acknowledging.

The data line is driven only through an open-drain enable, `sda_oe`, which pulls the line low when set. The array depth is `2**ADDR_W`. The length of the internal programming cycle is a count of system clocks, `WRITE_CYCLES`. While that cycle runs, the engine refuses every control byte. A master can therefore poll for completion by repeating a start and a write control byte until one is acknowledged.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and the engine waits for a start condition.
- R2: A control byte is accepted (acknowledged) only when bits 7:4 equal 1010 and bits 3:1 equal `strap_i`. Bit 0 set to 1 selects read and 0 selects write. On a mismatch, the engine gives no acknowledge and leaves the line released until the next start. Writes sent after a mismatch change no location.
- R3: After a write control byte, a high and then a low address byte are acknowledged and load the word pointer. Bits of the 16-bit address above `ADDR_W` are ignored.
- R4: Each acknowledged data byte goes to the pointer's location, and then only the low `PAGE_W` pointer bits advance, wrapping inside the page. The array changes only after a stop condition.
- R5: A current-address read returns the byte at the pointer. After a write, the pointer holds the location after the last byte written.
- R6: A random read (write control, two address bytes, repeated start, read control) returns the byte at the loaded address.
- R7: In a read, each master acknowledge yields the next location. After a master no-acknowledge, the engine keeps the line released.
- R8: During reads, the pointer advances over the whole array and wraps from the top address to 0.
- R9: For `WRITE_CYCLES` clocks after a stop that ends a write with data, no control byte is acknowledged. Afterwards, control bytes are acknowledged again.
- R10: A start condition discards data bytes not yet committed by a stop. A repeated start after such bytes leaves the array and the busy state unchanged.
- R11: `sda_oe` rises only while the synchronised clock line is low, so data changes never fall in a clock-high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Chip-select strap levels compared with control bits 3:1 |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
A bus edge reaches the engine after two synchroniser flops. The edge detect is combinational on the second stage, and `sda_oe` is registered on the next clock, so a response settles three system clocks after the SCL falling edge that calls for it. The bench drives each new data level a quarter bit (8 clocks) after SCL falls and raises SCL another 8 clocks later. It then compares `sda_oe` against the behavioural model on every clock of the 16-clock high phase, so the comparison never falls inside the three-clock settling window. Commit after stop is checked by waiting more than `WRITE_CYCLES` clocks before any read-back. The busy refusal is checked by polling within one byte time of the stop.

// File: rtl/see_pkg.sv
package see_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_READ
  } see_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/see_line_sync.sv
module see_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_i};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // Data edge while the clock stays high marks a bus condition.
  assign start_p  = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_p   = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/see_ram.sv
module see_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/see_page_writer.sv
module see_page_writer #(
  parameter int AW           = 11,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_we,
  input  logic [AW-1:0] byte_addr,
  input  logic [7:0]    byte_data,
  input  logic          drop,
  input  logic          commit,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]         pbuf [PAGE];
  logic [PAGE-1:0]    valid;
  logic [AW-1:PAGE_W] base;
  logic [CNT_W-1:0]   cnt;
  logic [PAGE_W-1:0]  idx;

  assign idx = cnt[PAGE_W-1:0];

  // Page buffer kept free of reset so it maps onto plain storage.
  always_ff @(posedge clk) begin
    if (byte_we && !busy) pbuf[byte_addr[PAGE_W-1:0]] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      base     <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt < CNT_W'(PAGE) && valid[idx]) begin
          mem_we   <= 1'b1;
          mem_addr <= {base, idx};
          mem_data <= pbuf[idx];
        end
        if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end else if (byte_we) begin
        valid[byte_addr[PAGE_W-1:0]] <= 1'b1;
        base <= byte_addr[AW-1:PAGE_W];
      end else if (drop) begin
        valid <= '0;
      end else if (commit && |valid) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  // R4
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);
  import see_pkg::*;

  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_p, stop_p;
  logic wr_busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data, rdata;

  see_state_e        state;
  logic [3:0]        nrise;
  logic [7:0]        shreg, tx, addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic              mack, ctrl_ack;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [15:0]       word;
  logic [PAGE_W-1:0] ptr_lo_nx;
  logic              ctrl_match;

  assign word       = {addr_hi, shreg};
  assign ptr_lo_nx  = PAGE_W'(ptr[PAGE_W-1:0] + 1'b1);
  assign ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_i) && !wr_busy;

  see_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p)
  );

  see_page_writer #(.AW(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_pw (
    .clk(clk), .rst(rst), .byte_we(wr_stb), .byte_addr(wr_addr),
    .byte_data(wr_data), .drop(start_p), .commit(stop_p), .busy(wr_busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  see_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      nrise    <= '0;
      shreg    <= '0;
      tx       <= '0;
      addr_hi  <= '0;
      ptr      <= '0;
      mack     <= 1'b0;
      ctrl_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb   <= 1'b0;
      ctrl_ack <= 1'b0;
      if (start_p) begin
        state  <= ST_CTRL;
        nrise  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        state  <= ST_IDLE;
        nrise  <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (nrise != ACK_BIT) nrise <= nrise + 1'b1;
          if (nrise < LAST_BIT) shreg <= {shreg[6:0], sda_lvl};
          if (nrise == LAST_BIT) mack <= ~sda_lvl;
        end else if (scl_fall) begin
          if (state == ST_READ) begin
            if (nrise == LAST_BIT) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
            end else if (nrise == ACK_BIT) begin
              nrise <= '0;
              if (mack) begin
                tx     <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                state <= ST_IDLE;
              end
            end else if (nrise != 4'd0) begin
              sda_oe <= ~tx[3'd7 - nrise[2:0]];
            end
          end else if (nrise == LAST_BIT) begin
            unique case (state)
              ST_CTRL: begin
                if (ctrl_match) begin
                  sda_oe   <= 1'b1;
                  ctrl_ack <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_AHI: begin
                sda_oe  <= 1'b1;
                addr_hi <= shreg;
              end
              ST_ALO: begin
                sda_oe <= 1'b1;
                ptr    <= word[ADDR_W-1:0];
              end
              ST_WDAT: begin
                sda_oe  <= 1'b1;
                wr_stb  <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr_lo_nx};
              end
              default: ;
            endcase
          end else if (nrise == ACK_BIT) begin
            sda_oe <= 1'b0;
            nrise  <= '0;
            unique case (state)
              ST_CTRL: begin
                if (shreg[0]) begin
                  state  <= ST_READ;
                  tx     <= rdata;
                  sda_oe <= ~rdata[7];
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI:  state <= ST_ALO;
              ST_ALO:  state <= ST_WDAT;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && state == ST_IDLE));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
  // R9
  no_busy_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_ack |-> !wr_busy);
  // R11
  low_phase_drive_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
endmodule

// File: tb/test_serial_eeprom_slave.sv
`timescale 1ns/1ps
module test_serial_eeprom_slave;
  localparam int AW = 11;
  localparam int WC = 2000;
  localparam int Q  = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit mism;
  bit done = 0;
  int mdl_mem [DEPTH];
  int mdl_ptr = 0;

  always #2.5 clk = ~clk;

  serial_eeprom_slave #(.ADDR_W(AW), .PAGE_W(5), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) i_serial_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, act, exp);
    end
  endtask

  // One bit slot; compares sda_oe with the model on every high-phase clock.
  task automatic bus_bit(input logic b, input int exp_oe, output logic seen);
    tick(Q); m_sda = b; tick(Q); m_scl = 1'b1;
    seen = 1'b1;
    for (int k = 0; k < 2*Q; k++) begin
      tick(1);
      if (exp_oe >= 0 && sda_oe !== exp_oe[0]) mism = 1;
      if (k == Q) seen = sda_line;
    end
    m_scl = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    mism = 0;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 0, s);
    bus_bit(1'b1, exp_ack ? 1 : 0, s);
    check(!mism && (s == ~exp_ack), req, {31'd0, s}, {31'd0, ~exp_ack});
  endtask

  task automatic get_byte(input int expv, input logic ack, input string req);
    logic s;
    logic [7:0] v;
    mism = 0;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, expv[i] ? 0 : 1, s);
      v[i] = s;
    end
    bus_bit(~ack, 0, s);
    check(!mism && (v == expv[7:0]), req, {24'd0, v}, expv);
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
  endtask

  task automatic stop_c();
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] cs, input logic rd);
    return {4'b1010, cs, rd};
  endfunction

  task automatic send_addr(input int addr, input string req);
    put_byte({5'b10101, addr[10:8]}, 1, req);   // R3: junk upper bits
    put_byte(addr[7:0], 1, req);
  endtask

  task automatic do_write(input int addr, input int n, input logic [7:0] d [4], input bit settle);
    int base;
    int lo;
    base = addr & ~31;
    lo   = addr & 31;
    start_c();
    put_byte(ctrl(STRAP, 0), 1, "R2");
    send_addr(addr, "R3");
    for (int k = 0; k < n; k++) begin
      put_byte(d[k], 1, "R4");
      mdl_mem[base | ((lo + k) % 32)] = d[k];
    end
    stop_c();
    mdl_ptr = base | ((lo + n) % 32);
    if (settle) tick(WC + 100);
  endtask

  task automatic read_seq(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      get_byte(mdl_mem[mdl_ptr], k < n - 1, req);
      mdl_ptr = (mdl_ptr + 1) % DEPTH;
    end
  endtask

  task automatic do_rand(input int addr, input int n, input string req);
    start_c();
    put_byte(ctrl(STRAP, 0), 1, req);
    send_addr(addr, req);
    mdl_ptr = addr;
    start_c();
    put_byte(ctrl(STRAP, 1), 1, req);
    read_seq(n, req);
    stop_c();
  endtask

  task automatic do_cur(input int n, input string req);
    start_c();
    put_byte(ctrl(STRAP, 1), 1, req);
    read_seq(n, req);
    stop_c();
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = -1;
    tick(6);
    check(sda_oe === 1'b0, "R1", {31'd0, sda_oe}, 0);
    rst = 1'b0;
    tick(20);
    check(sda_oe === 1'b0, "R1", {31'd0, sda_oe}, 0);

    // R4: page wrap 0x01E -> 0x01F -> 0x000
    d = '{8'hC1, 8'hC2, 8'hC3, 8'h00};
    do_write(11'h01E, 3, d, 1);
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(11'h120, 4, d, 1);
    // R3: byte write overwrites one location
    d = '{8'hA5, 8'h00, 8'h00, 8'h00};
    do_write(11'h122, 1, d, 1);
    // R5: current read after write yields 0x123
    do_cur(1, "R5");
    // R6 / R7: random then sequential with final no-acknowledge
    do_rand(11'h120, 3, "R7");
    do_rand(11'h01E, 2, "R4");
    do_rand(11'h000, 1, "R6");
    // R8: read wraps top of array to zero
    d = '{8'h7E, 8'h7F, 8'h00, 8'h00};
    do_write(11'h7FE, 2, d, 1);
    do_rand(11'h7FE, 3, "R8");

    // R2: strap mismatch and wrong device code are ignored
    start_c();
    put_byte(ctrl(3'b010, 0), 0, "R2");
    put_byte(8'h01, 0, "R2");
    put_byte(8'h22, 0, "R2");
    put_byte(8'hEE, 0, "R2");
    stop_c();
    start_c();
    put_byte({4'b1011, STRAP, 1'b0}, 0, "R2");
    stop_c();
    start_c();
    put_byte(ctrl(STRAP, 0), 1, "R2");
    stop_c();
    do_rand(11'h122, 1, "R2");

    // R9: refusal during the internal write, acceptance after it
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    do_write(11'h300, 1, d, 0);
    start_c();
    put_byte(ctrl(STRAP, 0), 0, "R9");
    stop_c();
    tick(WC + 100);
    start_c();
    put_byte(ctrl(STRAP, 0), 1, "R9");
    stop_c();
    do_rand(11'h300, 1, "R9");

    // R10: data bytes before a repeated start are discarded
    d = '{8'h66, 8'h00, 8'h00, 8'h00};
    do_write(11'h310, 1, d, 1);
    start_c();
    put_byte(ctrl(STRAP, 0), 1, "R10");
    send_addr(11'h310, "R10");
    put_byte(8'h77, 1, "R10");
    start_c();
    put_byte(ctrl(STRAP, 0), 1, "R10");
    send_addr(11'h310, "R10");
    mdl_ptr = 11'h310;
    start_c();
    put_byte(ctrl(STRAP, 1), 1, "R10");
    read_seq(1, "R10");
    stop_c();
    start_c();
    put_byte(ctrl(STRAP, 0), 1, "R10");
    stop_c();
    tick(20);
    check(sda_oe === 1'b0, "R2", {31'd0, sda_oe}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule